// File: doc/BRIEF.md
# Reference Selection Mode Controller

This block decides which of three timing references a clock synchroniser follows and which operating mode the loop is in. Each reference has four failure flags from its monitors: single-cycle, coarse-frequency, precise-frequency and guard-soak. A per-reference mask removes the flags that should not count. After a failure clears, a wait-to-restore timer that counts a one-second tick keeps the reference out of use for a set time. Only then does the reference count as usable.

Four modes are tracked: free-run, lock acquisition, normal (locked) and holdover. In automatic operation the usable reference with the lowest priority number wins, and a tie goes to the lowest index. A usable reference that is currently selected is given up for a better one only when that better reference has its revertive enable set. In manual operation the software-chosen reference is used whenever it is usable. The level of the mode-select pin while reset is high decides whether the controller runs at all or stays in free-run. Every change of mode or of the selected reference raises a one-cycle interrupt pulse.

Top module: `refsel_mode_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mode_o is 0 (free-run), sel_ref_o is 0, and lock_o, holdover_o and irq_o are all low.
- R2: The controller samples mode_pin while reset is high. If the sampled level is low, mode_o stays 0 (free-run) until the next reset, whatever the reference flags are and whatever mode_pin does after reset. If it is high, mode selection runs.
- R3: From free-run (0) or holdover (3), the controller moves to lock acquisition (1) one clock after a reference becomes usable, with sel_ref_o set to the reference chosen by R7 or R11.
- R4: In lock acquisition, a high phase_lock with no pending reference change moves the mode to normal (2) on the next clock. lock_o is high exactly while mode_o is 2, and it stays low while phase_lock is low.
- R5: If the selected reference stops being usable while in normal or lock acquisition and another reference is usable, the controller selects that other reference and goes to lock acquisition (1) on the next clock.
- R6: When no reference is usable (in manual mode: when the chosen one is not usable), modes 1 and 2 go to holdover (3) on the next clock. holdover_o is high exactly while mode_o is 3.
- R7: In automatic mode the usable reference with the smallest priority field wins, and on equal priority the lowest index wins. Priority field r is prio[r*PRIO_W +: PRIO_W].
- R8: A selected reference that is still usable is left for a usable one with a strictly smaller priority only if revert_en[index of that better one] is 1. Otherwise the selection holds.
- R9: Reference r is failed when any bit of mon_fail[r*4 +: 4] (bit 0 single-cycle, 1 coarse frequency, 2 precise frequency, 3 guard soak) is 1 while the matching bit of mon_mask is 0. A masked flag has no effect.
- R10: While a reference is failed its timer reloads from wtr_time. After the failure clears, the timer decrements once per clock that has sec_tick high. The reference is usable only when it is not failed and the timer is 0, so a wtr_time of 0 makes it usable in the same cycle the failure clears.
- R11: With manual_en high, the target is manual_ref. If that reference is usable the controller selects it, otherwise it behaves as in R6.
- R12: irq_o is high for exactly the cycles in which mode_o or sel_ref_o holds a value that differs from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Strap sampled during reset: 1 run, 0 free-run only |
| manual_en | input | 1 | 1 selects manual reference choice |
| manual_ref | input | REF_IDX_W | Reference index used in manual mode |
| mon_fail | input | NUM_REFS*4 | Monitor failure flags, four per reference |
| mon_mask | input | NUM_REFS*4 | 1 ignores the matching failure flag |
| prio | input | NUM_REFS*PRIO_W | Per-reference priority, smaller is preferred |
| revert_en | input | NUM_REFS | Per-reference revertive enable |
| wtr_time | input | WTR_W | Wait-to-restore interval in ticks |
| sec_tick | input | 1 | One-second tick strobe |
| phase_lock | input | 1 | Phase lock reported by the loop |
| sel_ref_o | output | REF_IDX_W | Selected reference index |
| mode_o | output | 2 | 0 free-run, 1 acquisition, 2 normal, 3 holdover |
| lock_o | output | 1 | High in normal mode |
| holdover_o | output | 1 | High in holdover |
| irq_o | output | 1 | One-cycle pulse on mode or selection change |

## Verification
A revertive switch and the lock-acquisition exit can be due in the same cycle. This is provoked by keeping phase_lock high while a better revertive reference appears, or while manual_ref moves to another usable reference. The expected result is that the reference change wins: the controller stays in acquisition with the new index, and normal mode comes only on the following clock. A second case is the wait-to-restore expiry that coincides with the last tick. The bench holds the tick for exactly wtr_time cycles and expects no switch on that edge, only on the one after.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_FREERUN  = 2'd0,
        MODE_ACQUIRE  = 2'd1,
        MODE_NORMAL   = 2'd2,
        MODE_HOLDOVER = 2'd3
    } sync_mode_e;

    localparam int MON_PER_REF = 4;

    // A flag counts only when its mask bit is clear.
    function automatic logic flags_failed(input logic [MON_PER_REF-1:0] flags,
                                          input logic [MON_PER_REF-1:0] mask);
        return |(flags & ~mask);
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refsel_ref_qual.sv
module refsel_ref_qual
    import refsel_pkg::*;
#(
    parameter int WTR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [MON_PER_REF-1:0] mon_fail,
    input  logic [MON_PER_REF-1:0] mon_mask,
    input  logic [WTR_W-1:0]       wtr_time,
    input  logic                   sec_tick,
    output logic                   usable
);

    logic             failed;
    logic [WTR_W-1:0] wtr_cnt_q;

    assign failed = flags_failed(mon_fail, mon_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            wtr_cnt_q <= '0;
        end else if (failed) begin
            wtr_cnt_q <= wtr_time;
        end else if (sec_tick && (wtr_cnt_q != '0)) begin
            wtr_cnt_q <= wtr_cnt_q - 1'b1;
        end
    end

    assign usable = !failed && (wtr_cnt_q == '0);

    // R10: without a tick and without a failure the timer must not move
    assert_wtr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!failed && !sec_tick) |=> $stable(wtr_cnt_q));

    // R10: a failure reloads the timer with the programmed interval
    assert_wtr_reload_R10: assert property (@(posedge clk) disable iff (rst)
        failed |=> (wtr_cnt_q == $past(wtr_time)));

endmodule

// File: rtl/refsel_prio_pick.sv
module refsel_prio_pick
    import refsel_pkg::*;
#(
    parameter int NUM_REFS = 3,
    parameter int PRIO_W   = 4,
    localparam int IDX_W   = idx_width(NUM_REFS)
) (
    input  logic [NUM_REFS-1:0]        usable,
    input  logic [NUM_REFS*PRIO_W-1:0] prio,
    output logic                       best_valid,
    output logic [IDX_W-1:0]           best_idx,
    output logic [PRIO_W-1:0]          best_prio
);

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_prio  = '0;
        for (int r = 0; r < NUM_REFS; r++) begin
            if (usable[r] && (!best_valid || (prio[r*PRIO_W +: PRIO_W] < best_prio))) begin
                best_valid = 1'b1;
                best_idx   = IDX_W'(r);
                best_prio  = prio[r*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/refsel_mode_fsm.sv
module refsel_mode_fsm
    import refsel_pkg::*;
#(
    parameter int NUM_REFS = 3,
    parameter int PRIO_W   = 4,
    localparam int IDX_W   = idx_width(NUM_REFS),
    localparam int NSLOT   = 2 ** IDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mode_pin,
    input  logic                       manual_en,
    input  logic [IDX_W-1:0]           manual_ref,
    input  logic [NUM_REFS-1:0]        usable,
    input  logic [NUM_REFS*PRIO_W-1:0] prio,
    input  logic [NUM_REFS-1:0]        revert_en,
    input  logic                       best_valid,
    input  logic [IDX_W-1:0]           best_idx,
    input  logic [PRIO_W-1:0]          best_prio,
    input  logic                       phase_lock,
    output sync_mode_e                 mode_q,
    output logic [IDX_W-1:0]           sel_q,
    output logic                       irq_q
);

    logic              run_en_q;
    sync_mode_e        mode_n;
    logic [IDX_W-1:0]  sel_n;
    logic [NSLOT-1:0]  usable_pad;
    logic [NSLOT-1:0]  revert_pad;
    logic [PRIO_W-1:0] prio_pad [NSLOT];
    logic [IDX_W-1:0]  tgt_idx;
    logic              tgt_valid;
    logic              tracking;

    for (genvar g = 0; g < NSLOT; g++) begin : g_pad
        if (g < NUM_REFS) begin : g_real
            assign usable_pad[g] = usable[g];
            assign revert_pad[g] = revert_en[g];
            assign prio_pad[g]   = prio[g*PRIO_W +: PRIO_W];
        end else begin : g_void
            assign usable_pad[g] = 1'b0;
            assign revert_pad[g] = 1'b0;
            assign prio_pad[g]   = '0;
        end
    end

    assign tracking = (mode_q == MODE_ACQUIRE) || (mode_q == MODE_NORMAL);

    // Target reference for this cycle.
    always_comb begin
        if (manual_en) begin
            tgt_idx   = manual_ref;
            tgt_valid = usable_pad[manual_ref];
        end else if (!tracking || !usable_pad[sel_q]) begin
            tgt_idx   = best_idx;
            tgt_valid = best_valid;
        end else if (best_valid && (best_prio < prio_pad[sel_q]) && revert_pad[best_idx]) begin
            tgt_idx   = best_idx;
            tgt_valid = 1'b1;
        end else begin
            tgt_idx   = sel_q;
            tgt_valid = 1'b1;
        end
    end

    always_comb begin
        mode_n = mode_q;
        sel_n  = sel_q;
        if (run_en_q) begin
            unique case (mode_q)
                MODE_FREERUN, MODE_HOLDOVER: begin
                    if (tgt_valid) begin
                        mode_n = MODE_ACQUIRE;
                        sel_n  = tgt_idx;
                    end
                end
                MODE_ACQUIRE: begin
                    if (!tgt_valid)              mode_n = MODE_HOLDOVER;
                    else if (tgt_idx != sel_q)   sel_n  = tgt_idx;
                    else if (phase_lock)         mode_n = MODE_NORMAL;
                end
                MODE_NORMAL: begin
                    if (!tgt_valid) begin
                        mode_n = MODE_HOLDOVER;
                    end else if (tgt_idx != sel_q) begin
                        mode_n = MODE_ACQUIRE;
                        sel_n  = tgt_idx;
                    end
                end
                default: mode_n = MODE_FREERUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en_q <= mode_pin;
            mode_q   <= MODE_FREERUN;
            sel_q    <= '0;
            irq_q    <= 1'b0;
        end else begin
            mode_q   <= mode_n;
            sel_q    <= sel_n;
            irq_q    <= (mode_n != mode_q) || (sel_n != sel_q);
        end
    end

    // R2: a low strap keeps the controller in free-run
    assert_freerun_strap_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en_q |-> (mode_q == MODE_FREERUN));

    // R4: normal mode is reached only from acquisition with lock reported
    assert_normal_entry_R4: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_NORMAL) && ($past(mode_q) != MODE_NORMAL))
        |-> (($past(mode_q) == MODE_ACQUIRE) && $past(phase_lock)));

    // R12: every change is flagged
    assert_irq_on_change_R12: assert property (@(posedge clk) disable iff (rst)
        ((mode_q != $past(mode_q)) || (sel_q != $past(sel_q))) |-> irq_q);

    // R12: no pulse without a change
    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ((mode_q != $past(mode_q)) || (sel_q != $past(sel_q))));

endmodule

// File: rtl/refsel_mode_ctrl.sv
module refsel_mode_ctrl
    import refsel_pkg::*;
#(
    parameter int NUM_REFS  = 3,
    parameter int PRIO_W    = 4,
    parameter int WTR_W     = 8,
    localparam int REF_IDX_W = idx_width(NUM_REFS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mode_pin,
    input  logic                            manual_en,
    input  logic [REF_IDX_W-1:0]            manual_ref,
    input  logic [NUM_REFS*MON_PER_REF-1:0] mon_fail,
    input  logic [NUM_REFS*MON_PER_REF-1:0] mon_mask,
    input  logic [NUM_REFS*PRIO_W-1:0]      prio,
    input  logic [NUM_REFS-1:0]             revert_en,
    input  logic [WTR_W-1:0]                wtr_time,
    input  logic                            sec_tick,
    input  logic                            phase_lock,
    output logic [REF_IDX_W-1:0]            sel_ref_o,
    output logic [1:0]                      mode_o,
    output logic                            lock_o,
    output logic                            holdover_o,
    output logic                            irq_o
);

    logic [NUM_REFS-1:0]  usable_vec;
    logic                 best_valid;
    logic [REF_IDX_W-1:0] best_idx;
    logic [PRIO_W-1:0]    best_prio;
    sync_mode_e           mode_q;

    for (genvar r = 0; r < NUM_REFS; r++) begin : g_ref
        refsel_ref_qual #(.WTR_W(WTR_W)) u_qual (
            .clk      (clk),
            .rst      (rst),
            .mon_fail (mon_fail[r*MON_PER_REF +: MON_PER_REF]),
            .mon_mask (mon_mask[r*MON_PER_REF +: MON_PER_REF]),
            .wtr_time (wtr_time),
            .sec_tick (sec_tick),
            .usable   (usable_vec[r])
        );
    end

    refsel_prio_pick #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_pick (
        .usable     (usable_vec),
        .prio       (prio),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_prio  (best_prio)
    );

    refsel_mode_fsm #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_pin   (mode_pin),
        .manual_en  (manual_en),
        .manual_ref (manual_ref),
        .usable     (usable_vec),
        .prio       (prio),
        .revert_en  (revert_en),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_prio  (best_prio),
        .phase_lock (phase_lock),
        .mode_q     (mode_q),
        .sel_q      (sel_ref_o),
        .irq_q      (irq_o)
    );

    assign mode_o     = mode_q;
    assign lock_o     = (mode_q == MODE_NORMAL);
    assign holdover_o = (mode_q == MODE_HOLDOVER);

    // R3: a newly taken reference was usable when it was taken
    assert_acquire_usable_R3: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_ACQUIRE) && (($past(mode_q) != MODE_ACQUIRE) || (sel_ref_o != $past(sel_ref_o))))
        |-> ((($past(usable_vec) >> sel_ref_o) & NUM_REFS'(1)) != '0));

    // R6: automatic holdover entry only when nothing was usable
    assert_holdover_no_ref_R6: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_HOLDOVER) && ($past(mode_q) != MODE_HOLDOVER) && !$past(manual_en))
        |-> ($past(usable_vec) == '0));

endmodule

// File: tb/refsel_mode_ctrl_tb.sv
module refsel_mode_ctrl_tb;

    localparam int N  = 3;
    localparam int PW = 4;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_pin;
    logic          manual_en;
    logic [1:0]    manual_ref;
    logic [N*4-1:0] mon_fail;
    logic [N*4-1:0] mon_mask;
    logic [N*PW-1:0] prio;
    logic [N-1:0]  revert_en;
    logic [WW-1:0] wtr_time;
    logic          sec_tick;
    logic          phase_lock;
    logic [1:0]    sel_ref_o;
    logic [1:0]    mode_o;
    logic          lock_o;
    logic          holdover_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    refsel_mode_ctrl #(.NUM_REFS(N), .PRIO_W(PW), .WTR_W(WW)) u_dut (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .manual_en(manual_en),
        .manual_ref(manual_ref), .mon_fail(mon_fail), .mon_mask(mon_mask),
        .prio(prio), .revert_en(revert_en), .wtr_time(wtr_time),
        .sec_tick(sec_tick), .phase_lock(phase_lock), .sel_ref_o(sel_ref_o),
        .mode_o(mode_o), .lock_o(lock_o), .holdover_o(holdover_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Full state check: mode, selection, indicators derived from mode, irq.
    task automatic expect_state(input string req, input int m, input int s, input int irq);
        chk(req, "mode", int'(mode_o), m);
        chk(req, "sel", int'(sel_ref_o), s);
        chk(req, "lock", int'(lock_o), (m == 2) ? 1 : 0);
        chk(req, "holdover", int'(holdover_o), (m == 3) ? 1 : 0);
        chk(req, "irq", int'(irq_o), irq);
    endtask

    task automatic set_fail(input int r, input logic [3:0] v);
        mon_fail[r*4 +: 4] = v;
    endtask

    task automatic set_prio(input int p0, input int p1, input int p2);
        prio = {PW'(p2), PW'(p1), PW'(p0)};
    endtask

    initial begin
        rst = 1'b1; mode_pin = 1'b1; manual_en = 1'b0; manual_ref = 2'd0;
        mon_fail = '1; mon_mask = '0; revert_en = '0; wtr_time = '0;
        sec_tick = 1'b0; phase_lock = 1'b0;
        set_prio(3, 1, 1);
        repeat (3) step();
        expect_state("R1", 0, 0, 0);
        rst = 1'b0;
        step();
        expect_state("R1", 0, 0, 0);

        // R3: one reference comes good
        set_fail(0, 4'h0);
        step();
        expect_state("R3", 1, 0, 1);
        step();
        expect_state("R12", 1, 0, 0);   // R4: no lock yet, stays in acquisition

        phase_lock = 1'b1;
        step();
        expect_state("R4", 2, 0, 1);

        // R8: better references appear, revertive disabled
        set_fail(1, 4'h0); set_fail(2, 4'h0);
        step();
        expect_state("R8", 2, 0, 0);
        revert_en = 3'b100;             // best is ref1 (tie, R7), not revertive
        step();
        expect_state("R8", 2, 0, 0);
        revert_en = 3'b110;
        step();
        expect_state("R7", 1, 1, 1);    // R8: reverts to ref1 while lock still high
        step();
        expect_state("R4", 2, 1, 1);

        // R9: masked precise-frequency failure is ignored
        mon_mask[1*4 + 2] = 1'b1;
        set_fail(1, 4'b0100);
        step();
        expect_state("R9", 2, 1, 0);
        mon_mask = '0;
        step();
        expect_state("R5", 1, 2, 1);    // R9: unmasked, ref2 (prio 1) beats ref0
        step();
        expect_state("R5", 2, 2, 1);

        // R10: wait-to-restore of 3 ticks on ref1
        set_prio(3, 1, 2);
        wtr_time = 8'd3;
        step();
        set_fail(1, 4'h0);
        step(); step();
        expect_state("R10", 2, 2, 0);
        sec_tick = 1'b1;
        for (int k = 0; k < 3; k++) step();
        sec_tick = 1'b0;
        expect_state("R10", 2, 2, 0);
        step();
        expect_state("R10", 1, 1, 1);
        step();
        expect_state("R8", 2, 1, 1);

        // R6: everything fails
        mon_fail = '1;
        wtr_time = 8'd0;
        step();
        expect_state("R6", 3, 1, 1);
        step();
        expect_state("R6", 3, 1, 0);
        set_fail(0, 4'h0); set_fail(2, 4'h0);
        step();
        expect_state("R6", 1, 2, 1);    // R7, R10: immediate restore, ref2 wins

        // R11: manual selection
        manual_en = 1'b1; manual_ref = 2'd0;
        step();
        expect_state("R11", 1, 0, 1);
        step();
        expect_state("R11", 2, 0, 1);
        manual_ref = 2'd1;
        step();
        expect_state("R11", 3, 0, 1);
        set_fail(1, 4'h0);
        step();
        expect_state("R11", 1, 1, 1);
        manual_en = 1'b0;

        // R2: low strap during reset
        rst = 1'b1; mode_pin = 1'b0; mon_fail = '0;
        step(); step();
        expect_state("R1", 0, 0, 0);
        rst = 1'b0;
        repeat (3) step();
        expect_state("R2", 0, 0, 0);
        mode_pin = 1'b1;
        repeat (2) step();
        expect_state("R2", 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule